// File: doc/BRIEF.md
# Funnel Shift Left Unit

This execution unit joins two 32-bit operands into one 64-bit pair, the high word above the low word. It shifts that pair left and returns the upper 32 bits of the shifted result. The shift count comes from either a 6-bit immediate or a 32-bit register operand. A width-type field selects a 32-bit or a 64-bit operation size. A wrap bit chooses how an out-of-range count is handled: it is either masked to the operation size or clamped into range as a signed value.

The unit takes one operation per cycle, marked by a valid strobe. The result, a valid flag and two diagnostic flags are registered and appear one cycle later. The first diagnostic flag marks a reserved width-type code. The second marks a request for an extended mode, which the unit does not support.

Top module: `funnel_shl_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_data`, `out_type_err` and `out_mode_err` are all cleared to 0 at that edge.
- R2: `out_valid` equals `in_valid` delayed by one clock. On a cycle where `in_valid` is low, `out_data` and both flags keep their previous values.
- R3: When `imm_sel` is 1, the raw count is `sh_imm` zero-extended to 32 bits and `sh_reg` is ignored. When `imm_sel` is 0, the raw count is `sh_reg`.
- R4: The operation size is 32 when `width_type` is 0 or 1 and 64 when `width_type` is 2 or 3. For any count s, the result is bits 63..32 of the 64-bit value {`hi_op`,`lo_op`} shifted left by s.
- R5: When `wrap_en` is 1, the effective count s is the raw count bitwise-ANDed with (size − 1).
- R6: When `wrap_en` is 0, the raw count is read as a signed 32-bit integer and clamped to the range [0, size]. A negative count gives s = 0, so the result is `hi_op`.
- R7: At size 32, s = 0 gives `hi_op`, s = 32 gives `lo_op`, and 0 < s < 32 gives (`hi_op` << s) | (`lo_op` >> (32 − s)).
- R8: At size 64, s = 0 gives `hi_op` and 0 < s < 32 gives the same funnel result as R7. A count of 32 ≤ s < 64 gives `lo_op` << (s − 32), and s = 64 gives 0.
- R9: A `width_type` of 1 is reserved. It is computed as size 32 and sets `out_type_err` to 1 together with its result. Any other code sets `out_type_err` to 0.
- R10: A non-zero `ext_mode` sets `out_mode_err` to 1 together with its result. The result is the same as with `ext_mode` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| hi_op | input | 32 | High word of the pair |
| lo_op | input | 32 | Low word of the pair |
| sh_reg | input | 32 | Register shift count (signed when clamped) |
| sh_imm | input | 6 | Immediate shift count |
| imm_sel | input | 1 | 1 selects the immediate count |
| width_type | input | 2 | 0: 32-bit, 1: reserved (32-bit), 2: unsigned 64, 3: signed 64 |
| wrap_en | input | 1 | 1 masks the count, 0 clamps it |
| ext_mode | input | 2 | Extended mode request; non-zero is flagged |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Upper word of the shifted pair |
| out_type_err | output | 1 | Reserved width-type was used |
| out_mode_err | output | 1 | Extended mode was requested |

## Verification
The two diagnostic paths can fire in the same cycle as each other and as a boundary shift. The bench provokes this with an operation that has width type 1, a non-zero extended mode and a clamped count of 32. It then judges the two flags and the result separately: both flags must be set, and the result must equal `lo_op`, the 32-bit result for s = 32. A second combined case is a 64-bit operation at s = 64 with a non-zero extended mode, which must give zero data with only the mode flag set.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  typedef enum logic [1:0] {
    WT_W32  = 2'd0,
    WT_RSVD = 2'd1,
    WT_U64  = 2'd2,
    WT_S64  = 2'd3
  } width_type_e;

  // Double-width operation for codes 2 and 3.
  function automatic logic is_wide(input logic [1:0] wt);
    return wt[1];
  endfunction

  function automatic logic is_reserved(input logic [1:0] wt);
    return wt == WT_RSVD;
  endfunction
endpackage

// File: rtl/fsl_amount.sv
module fsl_amount #(
  parameter int W     = 32,
  parameter int IMM_W = 6,
  localparam int AMT_W = $clog2(2*W) + 1
) (
  input  logic [W-1:0]     sh_reg,
  input  logic [IMM_W-1:0] sh_imm,
  input  logic             imm_sel,
  input  logic             wide,
  input  logic             wrap_en,
  output logic [AMT_W-1:0] eff_amt
);
  localparam logic [W-1:0] SZ_N = W'(W);
  localparam logic [W-1:0] SZ_D = W'(2*W);

  logic [W-1:0] raw;
  logic [W-1:0] size_v;
  logic [W-1:0] picked;

  always_comb begin
    raw    = imm_sel ? W'(sh_imm) : sh_reg;
    size_v = wide ? SZ_D : SZ_N;
    if (wrap_en) begin
      picked = raw & (size_v - W'(1));
    end else if (raw[W-1]) begin
      picked = '0;
    end else if (raw > size_v) begin
      picked = size_v;
    end else begin
      picked = raw;
    end
    eff_amt = picked[AMT_W-1:0];
  end
endmodule

// File: rtl/fsl_core.sv
module fsl_core #(
  parameter int W = 32,
  localparam int AMT_W = $clog2(2*W) + 1
) (
  input  logic [W-1:0]     hi_op,
  input  logic [W-1:0]     lo_op,
  input  logic [AMT_W-1:0] eff_amt,
  output logic [W-1:0]     result
);
  localparam logic [AMT_W-1:0] ONE_W = AMT_W'(W);
  localparam logic [AMT_W-1:0] TWO_W = AMT_W'(2*W);

  always_comb begin
    if (eff_amt == '0) begin
      result = hi_op;
    end else if (eff_amt < ONE_W) begin
      result = (hi_op << eff_amt) | (lo_op >> (ONE_W - eff_amt));
    end else if (eff_amt < TWO_W) begin
      result = lo_op << (eff_amt - ONE_W);
    end else begin
      result = '0;
    end
  end
endmodule

// File: rtl/fsl_outreg.sv
module fsl_outreg #(
  parameter int W = 32,
  parameter int NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     d_data,
  input  logic [NFLAG-1:0] d_flag,
  output logic             q_valid,
  output logic [W-1:0]     q_data,
  output logic [NFLAG-1:0] q_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= in_valid;
      if (in_valid) q_data <= d_data;
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) q_flag[g] <= 1'b0;
      else if (in_valid) q_flag[g] <= d_flag[g];
    end
  end
endmodule

// File: rtl/funnel_shl_unit.sv
module funnel_shl_unit #(
  parameter int W     = 32,
  parameter int IMM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     hi_op,
  input  logic [W-1:0]     lo_op,
  input  logic [W-1:0]     sh_reg,
  input  logic [IMM_W-1:0] sh_imm,
  input  logic             imm_sel,
  input  logic [1:0]       width_type,
  input  logic             wrap_en,
  input  logic [1:0]       ext_mode,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic             out_type_err,
  output logic             out_mode_err
);
  import fsl_pkg::*;
  localparam int AMT_W = $clog2(2*W) + 1;

  logic             wide;
  logic [AMT_W-1:0] eff_amt;
  logic [W-1:0]     shifted;
  logic [1:0]       flags_d;
  logic [1:0]       flags_q;

  assign wide    = is_wide(width_type);
  assign flags_d = {ext_mode != 2'b00, is_reserved(width_type)};

  fsl_amount #(.W(W), .IMM_W(IMM_W)) u_amt (
    .sh_reg(sh_reg), .sh_imm(sh_imm), .imm_sel(imm_sel),
    .wide(wide), .wrap_en(wrap_en), .eff_amt(eff_amt)
  );

  fsl_core #(.W(W)) u_core (
    .hi_op(hi_op), .lo_op(lo_op), .eff_amt(eff_amt), .result(shifted)
  );

  fsl_outreg #(.W(W), .NFLAG(2)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .d_data(shifted), .d_flag(flags_d),
    .q_valid(out_valid), .q_data(out_data), .q_flag(flags_q)
  );

  assign out_type_err = flags_q[0];
  assign out_mode_err = flags_q[1];
endmodule

// File: rtl/funnel_shl_chk.sv
module funnel_shl_chk #(
  parameter int W = 32,
  parameter int AMT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [W-1:0]     sh_reg,
  input logic             imm_sel,
  input logic [1:0]       width_type,
  input logic             wrap_en,
  input logic [1:0]       ext_mode,
  input logic [AMT_W-1:0] eff_amt,
  input logic             out_valid,
  input logic [W-1:0]     out_data,
  input logic             out_type_err,
  input logic             out_mode_err
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && !out_type_err && !out_mode_err));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  a_r5_wrap_narrow: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wrap_en && !width_type[1]) |-> (eff_amt < AMT_W'(W)));

  a_r6_clamp_bound: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wrap_en && !width_type[1]) |-> (eff_amt <= AMT_W'(W)));

  a_r6_negative_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wrap_en && !imm_sel && sh_reg[W-1]) |-> (eff_amt == '0));

  a_r8_full_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_type[1] && eff_amt == AMT_W'(2*W)) |=> (out_data == '0));

  a_r9_type_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_type == 2'd1) |=> out_type_err);

  a_r10_mode_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ext_mode != 2'b00) |=> out_mode_err);
endmodule

bind funnel_shl_unit funnel_shl_chk #(.W(W), .AMT_W(AMT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sh_reg(sh_reg),
  .imm_sel(imm_sel), .width_type(width_type), .wrap_en(wrap_en),
  .ext_mode(ext_mode), .eff_amt(eff_amt), .out_valid(out_valid),
  .out_data(out_data), .out_type_err(out_type_err), .out_mode_err(out_mode_err)
);

// File: tb/funnel_shl_unit_test.sv
module funnel_shl_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] hi_op = '0, lo_op = '0, sh_reg = '0;
  logic [5:0]  sh_imm = '0;
  logic imm_sel = 1'b0, wrap_en = 1'b0;
  logic [1:0] width_type = '0, ext_mode = '0;
  logic out_valid, out_type_err, out_mode_err;
  logic [31:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] e_data = '0;
  logic e_valid = 1'b0, e_te = 1'b0, e_me = 1'b0;

  always #10 clk = ~clk;

  funnel_shl_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .hi_op(hi_op), .lo_op(lo_op),
    .sh_reg(sh_reg), .sh_imm(sh_imm), .imm_sel(imm_sel), .width_type(width_type),
    .wrap_en(wrap_en), .ext_mode(ext_mode), .out_valid(out_valid),
    .out_data(out_data), .out_type_err(out_type_err), .out_mode_err(out_mode_err)
  );

  function automatic logic [31:0] model(input logic [31:0] h, input logic [31:0] l,
                                        input logic [31:0] r, input logic [5:0] im,
                                        input logic isel, input logic [1:0] wt,
                                        input logic wr);
    int size = (wt >= 2) ? 64 : 32;
    int raw = isel ? int'(im) : int'($signed(r));
    int s;
    logic [63:0] pair;
    if (wr) s = raw & (size - 1);
    else if (raw < 0) s = 0;
    else if (raw > size) s = size;
    else s = raw;
    pair = {h, l};
    pair = pair << s;
    return pair[63:32];
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== e_valid || out_data !== e_data ||
        out_type_err !== e_te || out_mode_err !== e_me) begin
      fails++;
      $display("FAIL %s: got v=%b d=%h te=%b me=%b, expected v=%b d=%h te=%b me=%b",
               tag, out_valid, out_data, out_type_err, out_mode_err,
               e_valid, e_data, e_te, e_me);
    end
  endtask

  task automatic op(input logic v, input logic [31:0] h, input logic [31:0] l,
                    input logic [31:0] r, input logic [5:0] im, input logic isel,
                    input logic [1:0] wt, input logic wr, input logic [1:0] em,
                    input string tag);
    in_valid = v; hi_op = h; lo_op = l; sh_reg = r; sh_imm = im;
    imm_sel = isel; width_type = wt; wrap_en = wr; ext_mode = em;
    e_valid = v;
    if (v) begin
      e_data = model(h, l, r, im, isel, wt, wr);
      e_te = (wt == 2'd1);
      e_me = (em != 2'd0);
    end
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [31:0] H = 32'h8123_4567;
  localparam logic [31:0] L = 32'h89AB_CDEF;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0 || out_type_err !== 1'b0 || out_mode_err !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%b d=%h te=%b me=%b, expected all zero",
               out_valid, out_data, out_type_err, out_mode_err);
    end
    rst = 1'b0;

    // R7 32-bit boundaries and middle
    op(1, H, L, 32'd0,   6'd0, 0, 2'd0, 0, 2'd0, "R7 s0");
    if (out_data !== H) begin fails++; $display("FAIL R7: got %h expected %h", out_data, H); end
    checks++;
    op(1, H, L, 32'd5,   6'd0, 0, 2'd0, 0, 2'd0, "R7 s5");
    op(1, H, L, 32'd31,  6'd0, 0, 2'd0, 0, 2'd0, "R7 s31");
    op(1, H, L, 32'd100, 6'd0, 0, 2'd0, 0, 2'd0, "R6 clamp32");
    if (out_data !== L) begin fails++; $display("FAIL R7: got %h expected %h", out_data, L); end
    checks++;
    // R5 wrap
    op(1, H, L, 32'd37,  6'd0, 0, 2'd0, 1, 2'd0, "R5 wrap32");
    op(1, H, L, 32'h45,  6'd0, 0, 2'd2, 1, 2'd0, "R5 wrap64");
    // R6 negative
    op(1, H, L, -32'sd5, 6'd0, 0, 2'd3, 0, 2'd0, "R6 negative");
    // R8 64-bit
    op(1, H, L, 32'd0,   6'd0, 0, 2'd2, 0, 2'd0, "R8 s0");
    op(1, H, L, 32'd7,   6'd0, 0, 2'd2, 0, 2'd0, "R8 s7");
    op(1, H, L, 32'd32,  6'd0, 0, 2'd3, 0, 2'd0, "R8 s32");
    op(1, H, L, 32'd45,  6'd0, 0, 2'd2, 0, 2'd0, "R8 s45");
    op(1, H, L, 32'd0,   6'd63, 1, 2'd2, 0, 2'd0, "R8 s63");
    op(1, H, L, 32'd100, 6'd0, 0, 2'd2, 0, 2'd0, "R8 s64");
    if (out_data !== 32'd0) begin fails++; $display("FAIL R8: got %h expected 0", out_data); end
    checks++;
    // R3 immediate overrides register
    op(1, H, L, 32'hFFFF_FFF0, 6'd12, 1, 2'd0, 0, 2'd0, "R3 imm");
    op(1, H, L, 32'd3,   6'd40, 1, 2'd2, 0, 2'd0, "R3 imm64");
    // R4 size codes
    op(1, H, L, 32'd50,  6'd0, 0, 2'd3, 0, 2'd0, "R4 code3");
    op(1, H, L, 32'd50,  6'd0, 0, 2'd0, 0, 2'd0, "R4 code0");
    // R9 reserved type
    op(1, H, L, 32'd9,   6'd0, 0, 2'd1, 0, 2'd0, "R9 reserved");
    // R10 extended mode
    op(1, H, L, 32'd9,   6'd0, 0, 2'd0, 0, 2'd2, "R10 ext");
    // combined: both flags with s=32 boundary
    op(1, H, L, 32'd77,  6'd0, 0, 2'd1, 0, 2'd3, "R9 R10 combined");
    op(1, H, L, 32'd64,  6'd0, 0, 2'd2, 1, 2'd1, "R10 wrap64 zero");
    op(1, H, L, 32'd64,  6'd0, 0, 2'd2, 0, 2'd1, "R10 s64");
    // R2 hold while idle
    op(0, 32'h1, 32'h2, 32'd3, 6'd4, 0, 2'd0, 0, 2'd0, "R2 idle");
    op(0, 32'h5, 32'h6, 32'd7, 6'd1, 1, 2'd1, 1, 2'd3, "R2 idle flags");
    // R4 mixed patterns
    for (int i = 0; i < 60; i++) begin
      op(($urandom % 4) != 0, $urandom, $urandom,
         (($urandom % 2) != 0) ? 32'($urandom % 80) : 32'($urandom),
         6'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
         "R4 mixed");
    end
    // R1 reset mid-run
    in_valid = 1'b1; rst = 1'b1;
    e_valid = 0; e_data = '0; e_te = 0; e_me = 0;
    @(negedge clk);
    compare("R1 reset");
    rst = 1'b0;
    in_valid = 1'b0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule